// File: doc/BRIEF.md
# Double-Buffered DAC Command Controller

This block sits behind a two-wire serial slave front end and turns the received command and data bytes into the digital state of a 10-bit voltage DAC. It holds a staging (input) register, an output (DAC) register and a two-bit power-down register. A four-bit command nibble in the first byte selects one of four load and update options, a read request, or a power-down mode change. A command takes effect only at the acknowledge of the byte that completes it.

The front end gives three strobes to the block, each lasting one clock. The first marks a START or repeated START that addresses this device for writing. The second marks a STOP. The third marks the acknowledge falling edge of each received byte and comes with the byte value. The block drives the DAC code, an enable for the analog output buffer and a termination select. It also presents the two bytes that a read transaction returns. The byte positions of the data fields are set by the bus format. The widths are parameters and are checked at elaboration.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset the input and DAC registers hold 0 and the power-down register holds 11: term_sel = 11, buf_en = 0, dac_code = 0.
- R2: In the first byte of a frame, bits 7..4 carry the command and bits 3..0 carry value bits 9..6. In the second byte, bits 7..2 carry value bits 5..0, and bits 1..0 are ignored.
- R3: Command 1100 writes the value into both the input and the DAC register. The write happens on the clock edge that samples byte_ack for the second byte.
- R4: Command 1101 writes the value into the input register only, and dac_code does not change.
- R5: Command 1110 writes the old input register into the DAC register and the new value into the input register, both on the same edge.
- R6: Command 1111 copies the input register into the DAC register at the second byte acknowledge, and its data bits have no effect.
- R7: Commands 10xx (read request) and 00xx change no register.
- R8: Command 01xx writes first-byte bits 3..2 into the power-down register at the acknowledge of that byte. term_sel equals that register: 00 driven, 01 open, 10 1k, 11 100k. buf_en is 1 only for 00.
- R9: A data load while powered down still updates the registers. The DAC code is kept across power-down, and powering up presents it again.
- R10: If a STOP or a new START arrives before the completing acknowledge, no register changes. A START in the same cycle as a byte acknowledge discards that byte.
- R11: Bytes after the completing byte of a frame are ignored until the next START.
- R12: rb_hi = {0, 0, power-down bits, DAC bits 9..6} and rb_lo = {DAC bits 5..0, 0, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| frame_start | input | 1 | One-cycle strobe: START or repeated START, write addressed to this device |
| frame_stop | input | 1 | One-cycle strobe: STOP seen |
| byte_ack | input | 1 | One-cycle strobe: acknowledge edge of a received byte |
| byte_data | input | 8 | Received byte, valid with byte_ack |
| dac_code | output | 10 | DAC register contents |
| buf_en | output | 1 | Output buffer enable |
| term_sel | output | 2 | Termination select (00 driven, 01 open, 10 1k, 11 100k) |
| rb_hi | output | 8 | First readback byte |
| rb_lo | output | 8 | Second readback byte |

## Verification
Two pairs of events can fall in one clock edge. Command 1110 moves the old input value into the DAC register on the same edge that overwrites the input register. The bench sets up a known input value, sends a 1110 frame with a different value, and expects dac_code to show the older value. It then uses a 1111 transfer to bring out the newer one. The bench also raises frame_start in the very cycle that acknowledges the second byte of a pending load, and expects dac_code to stay the same.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

   // termination select, equal to the power-down register contents
   typedef enum logic [1:0] {
      TERM_NONE = 2'b00,
      TERM_OPEN = 2'b01,
      TERM_1K   = 2'b10,
      TERM_100K = 2'b11
   } term_e;

   // source of a DAC register write
   typedef enum logic [1:0] {
      XFER_NONE  = 2'b00,
      XFER_NEW   = 2'b01,
      XFER_INPUT = 2'b10
   } xfer_e;

   // upper two command bits select the command group
   localparam logic [1:0] GRP_PD = 2'b01;
   localparam logic [1:0] GRP_RD = 2'b10;
   localparam logic [1:0] GRP_LD = 2'b11;

   // lower two command bits inside the load group
   localparam logic [1:0] LD_BOTH  = 2'b00;
   localparam logic [1:0] LD_STAGE = 2'b01;
   localparam logic [1:0] LD_SWAP  = 2'b10;
   localparam logic [1:0] LD_XFER  = 2'b11;

endpackage

// File: rtl/dacctl_frame.sv
module dacctl_frame
   import dacctl_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CMD_W  = 4,
   parameter int DATA_W = 10,
   parameter int PD_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_stop,
   input  logic              byte_ack,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              wr_in,
   output xfer_e             xfer,
   output logic [DATA_W-1:0] new_val,
   output logic              pd_wr,
   output logic [PD_W-1:0]   pd_val
);

   localparam int HI_W = BYTE_W - CMD_W;
   localparam int LO_W = DATA_W - HI_W;

   typedef enum logic [1:0] {
      POS_CMD  = 2'b00,
      POS_DATA = 2'b01,
      POS_IDLE = 2'b10
   } pos_e;

   generate
      if (CMD_W != 4) begin : g_bad_cmd
         $error("dacctl_frame: command nibble must be 4 bits");
      end
      if (HI_W < PD_W) begin : g_bad_pd
         $error("dacctl_frame: power-down bits must fit the first data field");
      end
      if (LO_W > BYTE_W || LO_W < 1) begin : g_bad_lo
         $error("dacctl_frame: value must span exactly two bytes");
      end
   endgenerate

   pos_e             pos_q;
   logic [CMD_W-1:0] cmd_q;
   logic [HI_W-1:0]  hi_q;
   logic             take;

   assign take = byte_ack && !frame_start;

   always_comb begin
      wr_in   = 1'b0;
      xfer    = XFER_NONE;
      pd_wr   = 1'b0;
      pd_val  = byte_data[HI_W-1 -: PD_W];
      new_val = {hi_q, byte_data[BYTE_W-1 -: LO_W]};
      if (take && pos_q == POS_CMD && byte_data[BYTE_W-1 -: 2] == GRP_PD) begin
         pd_wr = 1'b1;
      end
      if (take && pos_q == POS_DATA && cmd_q[CMD_W-1 -: 2] == GRP_LD) begin
         case (cmd_q[1:0])
            LD_BOTH:  begin wr_in = 1'b1; xfer = XFER_NEW;   end
            LD_STAGE: begin wr_in = 1'b1;                    end
            LD_SWAP:  begin wr_in = 1'b1; xfer = XFER_INPUT; end
            default:  begin               xfer = XFER_INPUT; end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= POS_IDLE;
         cmd_q <= '0;
         hi_q  <= '0;
      end else if (frame_start) begin
         pos_q <= POS_CMD;
      end else if (frame_stop) begin
         pos_q <= POS_IDLE;
      end else if (byte_ack) begin
         case (pos_q)
            POS_CMD: begin
               cmd_q <= byte_data[BYTE_W-1 -: CMD_W];
               hi_q  <= byte_data[HI_W-1:0];
               pos_q <= POS_DATA;
            end
            POS_DATA: pos_q <= POS_IDLE;
            default:  pos_q <= POS_IDLE;
         endcase
      end
   end

   // R10
   stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stop && !frame_start) |=>
         (frame_start || !(wr_in || pd_wr || xfer != XFER_NONE)));

   // R11
   extra_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ack && !frame_start && (wr_in || xfer != XFER_NONE)) |=>
         (frame_start || !(wr_in || pd_wr || xfer != XFER_NONE)));

endmodule

// File: rtl/dacctl_regs.sv
module dacctl_regs
   import dacctl_pkg::*;
#(
   parameter int              DATA_W   = 10,
   parameter int              PD_W     = 2,
   parameter logic [PD_W-1:0] RESET_PD = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_in,
   input  xfer_e             xfer,
   input  logic [DATA_W-1:0] new_val,
   input  logic              pd_wr,
   input  logic [PD_W-1:0]   pd_val,
   output logic [DATA_W-1:0] dac_q,
   output logic [PD_W-1:0]   pd_q
);

   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] dac_d;

   always_comb begin
      case (xfer)
         XFER_NEW:   dac_d = new_val;
         XFER_INPUT: dac_d = in_q;
         default:    dac_d = dac_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         dac_q <= '0;
         pd_q  <= RESET_PD;
      end else begin
         if (wr_in) in_q <= new_val;
         dac_q <= dac_d;
         if (pd_wr) pd_q <= pd_val;
      end
   end

   // R4
   in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_in |=> $stable(in_q));

   // R7
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer == XFER_NONE) |=> $stable(dac_q));

   // R9
   pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_wr |=> $stable(pd_q));

   // R5
   xfer_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer == XFER_INPUT) |=> (dac_q == $past(in_q)));

   // R3
   load_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer == XFER_NEW && wr_in) |=> (dac_q == in_q));

endmodule

// File: rtl/dacctl_readback.sv
module dacctl_readback #(
   parameter int BYTE_W = 8,
   parameter int CMD_W  = 4,
   parameter int DATA_W = 10,
   parameter int PD_W   = 2
) (
   input  logic [DATA_W-1:0] dac_q,
   input  logic [PD_W-1:0]   pd_q,
   output logic [BYTE_W-1:0] rb_hi,
   output logic [BYTE_W-1:0] rb_lo
);

   localparam int HI_W  = BYTE_W - CMD_W;
   localparam int LO_W  = DATA_W - HI_W;
   localparam int PAD_H = BYTE_W - PD_W - HI_W;
   localparam int PAD_L = BYTE_W - LO_W;

   generate
      if (PAD_H > 0) begin : g_pad_hi
         assign rb_hi = {{PAD_H{1'b0}}, pd_q, dac_q[DATA_W-1 -: HI_W]};
      end else begin : g_full_hi
         assign rb_hi = {pd_q, dac_q[DATA_W-1 -: HI_W]};
      end
      if (PAD_L > 0) begin : g_pad_lo
         assign rb_lo = {dac_q[LO_W-1:0], {PAD_L{1'b0}}};
      end else begin : g_full_lo
         assign rb_lo = dac_q[LO_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
   import dacctl_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CMD_W  = 4,
   parameter int DATA_W = 10,
   parameter int PD_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_stop,
   input  logic              byte_ack,
   input  logic [BYTE_W-1:0] byte_data,
   output logic [DATA_W-1:0] dac_code,
   output logic              buf_en,
   output logic [PD_W-1:0]   term_sel,
   output logic [BYTE_W-1:0] rb_hi,
   output logic [BYTE_W-1:0] rb_lo
);

   generate
      if (PD_W != 2) begin : g_bad_pdw
         $error("dac_cmd_ctrl: termination select is two bits");
      end
   endgenerate

   logic              wr_in;
   xfer_e             xfer;
   logic [DATA_W-1:0] new_val;
   logic              pd_wr;
   logic [PD_W-1:0]   pd_val;
   logic [DATA_W-1:0] dac_q;
   logic [PD_W-1:0]   pd_q;

   dacctl_frame #(
      .BYTE_W(BYTE_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .PD_W(PD_W)
   ) i_frame (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .frame_stop(frame_stop),
      .byte_ack(byte_ack), .byte_data(byte_data),
      .wr_in(wr_in), .xfer(xfer), .new_val(new_val),
      .pd_wr(pd_wr), .pd_val(pd_val)
   );

   dacctl_regs #(
      .DATA_W(DATA_W), .PD_W(PD_W), .RESET_PD(TERM_100K)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_in(wr_in), .xfer(xfer), .new_val(new_val),
      .pd_wr(pd_wr), .pd_val(pd_val),
      .dac_q(dac_q), .pd_q(pd_q)
   );

   dacctl_readback #(
      .BYTE_W(BYTE_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .PD_W(PD_W)
   ) i_rb (
      .dac_q(dac_q), .pd_q(pd_q), .rb_hi(rb_hi), .rb_lo(rb_lo)
   );

   assign dac_code = dac_q;
   assign term_sel = pd_q;
   assign buf_en   = (pd_q == TERM_NONE);

   // R8
   pd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start == 1'b0 && byte_ack && byte_data[7:6] == GRP_PD && $past(frame_start))
         |=> (term_sel == $past(byte_data[3:2])));

endmodule

// File: tb/test_dac_cmd_ctrl.sv
module test_dac_cmd_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0;
   logic       frame_stop = 1'b0;
   logic       byte_ack = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [9:0] dac_code;
   logic       buf_en;
   logic [1:0] term_sel;
   logic [7:0] rb_hi;
   logic [7:0] rb_lo;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dac_cmd_ctrl i_dac_cmd_ctrl (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .frame_stop(frame_stop),
      .byte_ack(byte_ack), .byte_data(byte_data),
      .dac_code(dac_code), .buf_en(buf_en), .term_sel(term_sel),
      .rb_hi(rb_hi), .rb_lo(rb_lo)
   );

   typedef struct packed {
      logic [7:0] b0;
      logic [7:0] b1;
      logic [1:0] nb;
      logic [9:0] dac;
      logic [1:0] pd;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [0:NV-1] = '{
      '{8'h40, 8'h00, 2'd1, 10'h000, 2'b00},  // R8 power up
      '{8'hCA, 8'h94, 2'd2, 10'h2A5, 2'b00},  // R3 R2 load both
      '{8'hDF, 8'hFC, 2'd2, 10'h2A5, 2'b00},  // R4 stage 3FF
      '{8'hF5, 8'h0C, 2'd2, 10'h3FF, 2'b00},  // R6 transfer, data ignored
      '{8'hD0, 8'h07, 2'd2, 10'h3FF, 2'b00},  // R4 R2 stage 001, sub bits set
      '{8'hE5, 8'h54, 2'd2, 10'h001, 2'b00},  // R5 dac gets old 001, input 155
      '{8'hF0, 8'h00, 2'd2, 10'h155, 2'b00},  // R6 transfer 155
      '{8'h48, 8'h00, 2'd1, 10'h155, 2'b10},  // R8 1k
      '{8'h8F, 8'hFF, 2'd2, 10'h155, 2'b10},  // R7 read request
      '{8'hC8, 8'h00, 2'd2, 10'h200, 2'b10},  // R9 load while down
      '{8'h44, 8'h00, 2'd1, 10'h200, 2'b01},  // R8 open
      '{8'h40, 8'h00, 2'd1, 10'h200, 2'b00},  // R9 power up keeps code
      '{8'h0F, 8'hFC, 2'd2, 10'h200, 2'b00}   // R7 undefined group
   };

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag, logic [9:0] edac, logic [1:0] epd);
      chk({tag, " dac"}, {6'd0, dac_code}, {6'd0, edac});
      chk({tag, " term"}, {14'd0, term_sel}, {14'd0, epd});
      chk({tag, " buf_en R8"}, {15'd0, buf_en}, {15'd0, epd == 2'b00});
      chk({tag, " rb_hi R12"}, {8'd0, rb_hi}, {8'd0, 2'b00, epd, edac[9:6]});
      chk({tag, " rb_lo R12"}, {8'd0, rb_lo}, {8'd0, edac[5:0], 2'b00});
   endtask

   task automatic pulse_start();
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) frame_stop = 1'b1;
      @(negedge clk) frame_stop = 1'b0;
   endtask

   task automatic send_byte(logic [7:0] b);
      @(negedge clk) begin byte_data = b; byte_ack = 1'b1; end
      @(negedge clk) byte_ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_state("R1 reset", 10'h000, 2'b11);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_state("R1 after release", 10'h000, 2'b11);

      for (int i = 0; i < NV; i++) begin
         pulse_start();
         send_byte(VEC[i].b0);
         if (VEC[i].nb == 2'd2) send_byte(VEC[i].b1);
         pulse_stop();
         @(negedge clk);
         chk_state($sformatf("vector %0d", i), VEC[i].dac, VEC[i].pd);
      end

      // R10 abort by STOP after the command byte
      pulse_start();
      send_byte(8'hC0);
      pulse_stop();
      @(negedge clk);
      chk_state("R10 stop abort", 10'h200, 2'b00);

      // R10 start in the same cycle as the second acknowledge
      pulse_start();
      send_byte(8'hC0);
      @(negedge clk) begin frame_start = 1'b1; byte_ack = 1'b1; byte_data = 8'h00; end
      @(negedge clk) begin frame_start = 1'b0; byte_ack = 1'b0; end
      pulse_stop();
      @(negedge clk);
      chk_state("R10 start collision", 10'h200, 2'b00);

      // R11 extra bytes after a stage load, seen through a transfer
      pulse_start();
      send_byte(8'hD0);
      send_byte(8'h04);
      send_byte(8'hFF);
      send_byte(8'hFF);
      pulse_stop();
      @(negedge clk);
      chk_state("R11 extra after stage", 10'h200, 2'b00);
      pulse_start();
      send_byte(8'hF0);
      send_byte(8'h00);
      pulse_stop();
      @(negedge clk);
      chk_state("R11 staged value kept", 10'h001, 2'b00);

      // R11 power-down command followed by a stray byte
      pulse_start();
      send_byte(8'h4C);
      send_byte(8'hFF);
      pulse_stop();
      @(negedge clk);
      chk_state("R11 pd then stray byte", 10'h001, 2'b11);
      pulse_start();
      send_byte(8'h40);
      pulse_stop();
      @(negedge clk);
      chk_state("R9 restore after 100k", 10'h001, 2'b00);

      // R3 R8 two commands joined by a repeated start
      pulse_start();
      send_byte(8'hC3);
      send_byte(8'hFC);
      pulse_start();
      send_byte(8'h48);
      pulse_stop();
      @(negedge clk);
      chk_state("R3 repeated start", 10'h0FF, 2'b10);

      // R1 reset in the middle of operation
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      chk_state("R1 second reset", 10'h000, 2'b11);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule